// File: doc/BRIEF.md
# Fast System Call Transition Unit

This block models the architectural state change caused by a table-free fast system-call instruction and by its matching fast return in a 64-bit processor. It holds the architectural registers involved: instruction pointer, flags, the two scratch general registers that keep the return address and the saved flags, the code and stack selectors, the privilege level and the GS base. Next to them sits a small model-specific register file. It holds the enable bit, the selector pair, the entry target, the flag clear mask and the shadow GS base, and it is reached through an address/data port.

A call strobe sends execution to a fixed, programmed entry point. It does not look anything up in a table and it pushes nothing on a stack. The call saves the return address and the flags, clears the flags named by the mask, and drops the privilege level to 0. A return strobe undoes this. Before it commits, it checks that the saved return address is canonical. A swap strobe exchanges the GS base with its shadow copy. Each of these completes one clock after its strobe, and the result is flagged by a done pulse. When an operation is refused, the block raises a fault flag and commits no state. A register write-back port lets the surrounding pipeline set the scratch registers, the flags and the GS base.

Top module: `fastcall_xfer_unit`

## Requirements
- R1: After synchronous active-low reset: privilege level 3, pc 0, flags 0x2, scratch registers, selectors, GS base and every model-specific register 0. done, fault_ud and fault_gp are 0.
- R2: Model-specific registers are at these addresses: 0xC0000080 enable (only bit 0 is kept, the system-call enable; the other bits read 0), 0xC0000081 selector pair, 0xC0000082 entry target, 0xC0000084 flag clear mask, 0xC0000102 shadow GS base. A write takes effect at the next edge. A read returns the value combinationally. Any other address raises msr_fault in the same cycle, and a write to it changes nothing.
- R3: A permitted call sets rcx to next_pc, pc to the entry target and the privilege level to 0. cs becomes selector-pair bits 47:32 with bits 1:0 cleared, and ss becomes that cs plus 8.
- R4: On a call, r11 receives the flags with bit 16 (resume) cleared. The new flags are that value with every bit set in the clear mask also cleared.
- R5: A call while the enable bit is 0 raises fault_ud and changes no architectural state.
- R6: A permitted return sets pc from rcx and flags from r11. It sets cs to (selector-pair bits 63:48) + 16 with bits 1:0 set to 3, ss to that base + 8 with bits 1:0 set to 3, and the privilege level to 3.
- R7: A return while the enable bit is 0 raises fault_ud. A return or swap at a privilege level other than 0 raises fault_gp. Neither changes state, and the two fault flags are never high together.
- R8: A return whose rcx has bits 63:48 not all equal to bit 47 raises fault_gp. The privilege level stays 0 and nothing is committed.
- R9: A permitted swap exchanges gs_base with the shadow GS base, whose new value can be read through the register port. Two swaps restore both values.
- R10: When strobes coincide, call wins over return, and return wins over swap. Only the winner takes effect.
- R11: done is high for exactly the one cycle after each cycle with a strobe. A fault flag is only ever high together with done.
- R12: With no strobe active, wb_en writes wb_data at the next edge into the register picked by wb_sel (0 rcx, 1 r11, 2 flags, 3 GS base).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msr_wr | input | 1 | Model-specific register write strobe |
| msr_rd | input | 1 | Model-specific register read strobe |
| msr_addr | input | 32 | Model-specific register address |
| msr_wdata | input | 64 | Write data |
| msr_rdata | output | 64 | Read data (combinational) |
| msr_fault | output | 1 | Unimplemented address accessed |
| wb_en | input | 1 | Register write-back enable |
| wb_sel | input | 2 | Write-back target select |
| wb_data | input | 64 | Write-back data |
| call_req | input | 1 | Fast call strobe |
| ret_req | input | 1 | Fast return strobe |
| swap_req | input | 1 | GS base swap strobe |
| next_pc | input | 64 | Address of the instruction after the call |
| done | output | 1 | Operation completed (one cycle after strobe) |
| fault_ud | output | 1 | Invalid-opcode fault |
| fault_gp | output | 1 | General-protection fault |
| pc | output | 64 | Instruction pointer |
| rflags | output | 64 | Flags register |
| rcx | output | 64 | Return-address scratch register |
| r11 | output | 64 | Saved-flags scratch register |
| cs_sel | output | 16 | Code selector |
| ss_sel | output | 16 | Stack selector |
| cpl | output | 2 | Current privilege level |
| gs_base | output | 64 | Active GS base |

## Verification
On every cycle, the assertions check that each strobe produces done on the next cycle and that a fault never moves pc or the privilege level. They also check that the two fault flags are exclusive, that a completed return lands on a canonical pc, that a completed call ends at level 0, and that a swap moves the old GS base into the shadow register. The exact register values need the bench's scenarios. These are the saved and masked flags, the selector arithmetic, the round trip of pc through rcx, the double swap and the strobe priority, and the bench's reference model predicts each of them.

// File: rtl/fcx_pkg.sv
// Package: shared constants for the fast system call transition unit.
// Assumes 32-bit model-specific register addresses.
package fcx_pkg;
    localparam logic [31:0] ADDR_ENABLE = 32'hC000_0080;
    localparam logic [31:0] ADDR_SELPR  = 32'hC000_0081;
    localparam logic [31:0] ADDR_TARGET = 32'hC000_0082;
    localparam logic [31:0] ADDR_CLRMSK = 32'hC000_0084;
    localparam logic [31:0] ADDR_SHADGS = 32'hC000_0102;

    typedef enum logic [1:0] {
        WB_RCX   = 2'd0,
        WB_R11   = 2'd1,
        WB_FLAGS = 2'd2,
        WB_GS    = 2'd3
    } wb_sel_e;
endpackage

// File: rtl/fcx_msr_file.sv
// Model-specific register file: enable bit, selector pair, entry target,
// flag clear mask and shadow GS base. Reads are combinational, writes land
// at the clock edge. A swap overrides a port write to the shadow register.
module fcx_msr_file
    import fcx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            rd,
    input  logic [31:0]     addr,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata,
    output logic            fault,
    input  logic            swap_en,
    input  logic [XLEN-1:0] swap_in,
    output logic            sce,
    output logic [XLEN-1:0] selpr,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] clrmsk,
    output logic [XLEN-1:0] shadgs
);
    logic hit;

    // Address decode and read mux.
    always_comb begin
        hit   = 1'b1;
        rdata = '0;
        unique case (addr)
            ADDR_ENABLE: rdata = {{(XLEN-1){1'b0}}, sce};
            ADDR_SELPR:  rdata = selpr;
            ADDR_TARGET: rdata = target;
            ADDR_CLRMSK: rdata = clrmsk;
            ADDR_SHADGS: rdata = shadgs;
            default:     hit   = 1'b0;
        endcase
        fault = (wr | rd) & ~hit;
    end

    // Register update from the port and from the swap path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sce    <= 1'b0;
            selpr  <= '0;
            target <= '0;
            clrmsk <= '0;
            shadgs <= '0;
        end else begin
            if (wr && addr == ADDR_ENABLE) sce    <= wdata[0];
            if (wr && addr == ADDR_SELPR)  selpr  <= wdata;
            if (wr && addr == ADDR_TARGET) target <= wdata;
            if (wr && addr == ADDR_CLRMSK) clrmsk <= wdata;
            if (swap_en)                   shadgs <= swap_in;
            else if (wr && addr == ADDR_SHADGS) shadgs <= wdata;
        end
    end

    AST_BAD_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit && !swap_en) |=> ($stable(sce) && $stable(selpr) && $stable(target) && $stable(clrmsk) && $stable(shadgs))); // R2
    AST_SWAP_TO_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |=> (shadgs == $past(swap_in))); // R9
endmodule

// File: rtl/fcx_flag_mask.sv
// Flag conditioning for a call: clears the resume bit to form the saved
// copy, then clears every bit named in the mask to form the new flags.
// Purely combinational.
module fcx_flag_mask #(
    parameter int XLEN   = 64,
    parameter int RF_BIT = 16
) (
    input  logic [XLEN-1:0] flags_in,
    input  logic [XLEN-1:0] clrmsk,
    output logic [XLEN-1:0] saved,
    output logic [XLEN-1:0] masked
);
    localparam logic [XLEN-1:0] RF_ONLY = XLEN'(1) << RF_BIT;

    // Resume bit first, then the programmable clear mask.
    always_comb begin
        saved  = flags_in & ~RF_ONLY;
        masked = saved & ~clrmsk;
    end
endmodule

// File: rtl/fcx_canon_chk.sv
// Canonical-address test: the bits above the implemented virtual width
// must all copy the top implemented bit. Purely combinational.
module fcx_canon_chk #(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 48
) (
    input  logic [XLEN-1:0] addr,
    output logic            ok
);
    localparam int TOP = XLEN - 1;
    localparam int LOW = VA_BITS - 1;

    // All ones or all zeros across the sign-extension field.
    always_comb ok = (&addr[TOP:LOW]) | ~(|addr[TOP:LOW]);
endmodule

// File: rtl/fastcall_xfer_unit.sv
// Fast system call transition unit: holds the architectural state touched
// by a fast call, a fast return and a GS swap, and updates it one clock
// after the request strobe. Assumes strobes are single-cycle requests from
// an issue stage; refused operations raise a fault flag and commit nothing.
module fastcall_xfer_unit
    import fcx_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 48,
    parameter int SEL_W   = 16,
    parameter int RF_BIT  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msr_wr,
    input  logic             msr_rd,
    input  logic [31:0]      msr_addr,
    input  logic [XLEN-1:0]  msr_wdata,
    output logic [XLEN-1:0]  msr_rdata,
    output logic             msr_fault,
    input  logic             wb_en,
    input  logic [1:0]       wb_sel,
    input  logic [XLEN-1:0]  wb_data,
    input  logic             call_req,
    input  logic             ret_req,
    input  logic             swap_req,
    input  logic [XLEN-1:0]  next_pc,
    output logic             done,
    output logic             fault_ud,
    output logic             fault_gp,
    output logic [XLEN-1:0]  pc,
    output logic [XLEN-1:0]  rflags,
    output logic [XLEN-1:0]  rcx,
    output logic [XLEN-1:0]  r11,
    output logic [SEL_W-1:0] cs_sel,
    output logic [SEL_W-1:0] ss_sel,
    output logic [1:0]       cpl,
    output logic [XLEN-1:0]  gs_base
);
    localparam int KSEL_LSB = 32;
    localparam int USEL_LSB = KSEL_LSB + SEL_W;
    localparam logic [SEL_W-1:0] RPL_MASK = SEL_W'(3);
    localparam logic [SEL_W-1:0] SS_OFS   = SEL_W'(8);
    localparam logic [SEL_W-1:0] UCS_OFS  = SEL_W'(16);
    localparam logic [XLEN-1:0]  FLAGS_RST = XLEN'(2);

    logic            sce;
    logic [XLEN-1:0] selpr, target, clrmsk, shadgs;
    logic [XLEN-1:0] fl_saved, fl_masked;
    logic            rcx_canon;
    logic            swap_go;
    logic [SEL_W-1:0] k_cs, u_base;

    fcx_msr_file #(.XLEN(XLEN)) u_msr (
        .clk(clk), .rst_n(rst_n), .wr(msr_wr), .rd(msr_rd), .addr(msr_addr),
        .wdata(msr_wdata), .rdata(msr_rdata), .fault(msr_fault),
        .swap_en(swap_go), .swap_in(gs_base), .sce(sce), .selpr(selpr),
        .target(target), .clrmsk(clrmsk), .shadgs(shadgs)
    );

    fcx_flag_mask #(.XLEN(XLEN), .RF_BIT(RF_BIT)) u_flags (
        .flags_in(rflags), .clrmsk(clrmsk), .saved(fl_saved), .masked(fl_masked)
    );

    fcx_canon_chk #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_canon (
        .addr(rcx), .ok(rcx_canon)
    );

    // Selector fields and the swap qualifier (swap wins only when alone and at level 0).
    always_comb begin
        k_cs    = selpr[KSEL_LSB +: SEL_W] & ~RPL_MASK;
        u_base  = selpr[USEL_LSB +: SEL_W];
        swap_go = swap_req && !call_req && !ret_req && (cpl == 2'd0);
    end

    // Architectural state update: one operation per cycle, call > return > swap > write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            rflags   <= FLAGS_RST;
            rcx      <= '0;
            r11      <= '0;
            cs_sel   <= '0;
            ss_sel   <= '0;
            cpl      <= 2'd3;
            gs_base  <= '0;
            done     <= 1'b0;
            fault_ud <= 1'b0;
            fault_gp <= 1'b0;
        end else begin
            done     <= call_req | ret_req | swap_req;
            fault_ud <= 1'b0;
            fault_gp <= 1'b0;
            if (call_req) begin
                if (!sce) begin
                    fault_ud <= 1'b1;
                end else begin
                    rcx    <= next_pc;
                    r11    <= fl_saved;
                    rflags <= fl_masked;
                    pc     <= target;
                    cs_sel <= k_cs;
                    ss_sel <= k_cs + SS_OFS;
                    cpl    <= 2'd0;
                end
            end else if (ret_req) begin
                if (!sce) begin
                    fault_ud <= 1'b1;
                end else if (cpl != 2'd0 || !rcx_canon) begin
                    fault_gp <= 1'b1;
                end else begin
                    pc     <= rcx;
                    rflags <= r11;
                    cs_sel <= (u_base + UCS_OFS) | RPL_MASK;
                    ss_sel <= (u_base + SS_OFS) | RPL_MASK;
                    cpl    <= 2'd3;
                end
            end else if (swap_req) begin
                if (cpl != 2'd0) fault_gp <= 1'b1;
                else             gs_base  <= shadgs;
            end else if (wb_en) begin
                unique case (wb_sel_e'(wb_sel))
                    WB_RCX:   rcx     <= wb_data;
                    WB_R11:   r11     <= wb_data;
                    WB_FLAGS: rflags  <= wb_data;
                    WB_GS:    gs_base <= wb_data;
                endcase
            end
        end
    end

    AST_REQ_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req || ret_req || swap_req) |=> done); // R11
    AST_FAULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ud || fault_gp) |-> done); // R11
    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_ud, fault_gp})); // R7
    AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ud || fault_gp) |-> (pc == $past(pc) && cpl == $past(cpl) && gs_base == $past(gs_base))); // R5
    AST_RET_LANDS_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cpl == 2'd3 && $past(cpl) == 2'd0) |->
        ((&pc[XLEN-1:VA_BITS-1]) || !(|pc[XLEN-1:VA_BITS-1]))); // R8
    AST_CALL_AT_LEVEL0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(call_req) && done && !fault_ud) |-> (cpl == 2'd0)); // R3
endmodule

// File: tb/fastcall_xfer_unit_tb_top.sv
// Scoreboard bench: driver tasks update a reference model and push the
// expected architectural state; a monitor pops and compares on done.
module fastcall_xfer_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msr_wr = 1'b0, msr_rd = 1'b0;
    logic [31:0] msr_addr = '0;
    logic [63:0] msr_wdata = '0, msr_rdata;
    logic        msr_fault;
    logic        wb_en = 1'b0;
    logic [1:0]  wb_sel = '0;
    logic [63:0] wb_data = '0;
    logic        call_req = 1'b0, ret_req = 1'b0, swap_req = 1'b0;
    logic [63:0] next_pc = '0;
    logic        done, fault_ud, fault_gp;
    logic [63:0] pc, rflags, rcx, r11, gs_base;
    logic [15:0] cs_sel, ss_sel;
    logic [1:0]  cpl;

    always #5 clk = ~clk;

    fastcall_xfer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .msr_wr(msr_wr), .msr_rd(msr_rd),
        .msr_addr(msr_addr), .msr_wdata(msr_wdata), .msr_rdata(msr_rdata),
        .msr_fault(msr_fault), .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
        .call_req(call_req), .ret_req(ret_req), .swap_req(swap_req),
        .next_pc(next_pc), .done(done), .fault_ud(fault_ud), .fault_gp(fault_gp),
        .pc(pc), .rflags(rflags), .rcx(rcx), .r11(r11), .cs_sel(cs_sel),
        .ss_sel(ss_sel), .cpl(cpl), .gs_base(gs_base)
    );

    typedef struct {
        string       tag;
        logic        ud, gp;
        logic [63:0] pc, fl, rcx, r11, gs;
        logic [15:0] cs, ss;
        logic [1:0]  cpl;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0, n_bad = 0;
    bit   finished = 1'b0;

    // Reference model of the architectural and model-specific registers.
    logic [63:0] m_pc = 0, m_fl = 64'h2, m_rcx = 0, m_r11 = 0, m_gs = 0, m_kgs = 0;
    logic [63:0] m_sel = 0, m_tgt = 0, m_msk = 0;
    logic [15:0] m_cs = 0, m_ss = 0;
    logic [1:0]  m_cpl = 2'd3;
    logic        m_sce = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic bit canon(input logic [63:0] a);
        return (&a[63:47]) || !(|a[63:47]);
    endfunction

    // Driver: apply strobes, update the model, push the expected state.
    task automatic do_op(input bit c, input bit r, input bit s, input logic [63:0] npc, input string tag);
        exp_t e;
        logic [15:0] kc;
        @(negedge clk);
        e.ud = 0; e.gp = 0; e.tag = tag;
        if (c) begin
            if (!m_sce) e.ud = 1;
            else begin
                kc = m_sel[47:32] & 16'hFFFC;
                m_rcx = npc; m_r11 = m_fl & ~(64'h1 << 16); m_fl = m_r11 & ~m_msk;
                m_pc = m_tgt; m_cs = kc; m_ss = kc + 16'd8; m_cpl = 0;
            end
        end else if (r) begin
            if (!m_sce) e.ud = 1;
            else if (m_cpl != 0 || !canon(m_rcx)) e.gp = 1;
            else begin
                m_pc = m_rcx; m_fl = m_r11;
                m_cs = (m_sel[63:48] + 16'd16) | 16'd3;
                m_ss = (m_sel[63:48] + 16'd8) | 16'd3; m_cpl = 3;
            end
        end else if (s) begin
            if (m_cpl != 0) e.gp = 1;
            else begin logic [63:0] t; t = m_gs; m_gs = m_kgs; m_kgs = t; end
        end
        e.pc = m_pc; e.fl = m_fl; e.rcx = m_rcx; e.r11 = m_r11; e.gs = m_gs;
        e.cs = m_cs; e.ss = m_ss; e.cpl = m_cpl;
        exp_q.push_back(e);
        call_req = c; ret_req = r; swap_req = s; next_pc = npc;
        @(negedge clk);
        call_req = 0; ret_req = 0; swap_req = 0;
        chk(done == 1'b1, {tag, " R11 done"}, {63'd0, done}, 64'd1);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R11 single pulse"}, {63'd0, done}, 64'd0);
    endtask

    // Monitor: pop and compare on each done.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) chk(0, "R11 unexpected done", 64'd1, 64'd0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(fault_ud == e.ud && fault_gp == e.gp, {e.tag, " fault"}, {62'd0, fault_ud, fault_gp}, {62'd0, e.ud, e.gp});
                chk(pc == e.pc, {e.tag, " pc"}, pc, e.pc);
                chk(rflags == e.fl, {e.tag, " flags"}, rflags, e.fl);
                chk(rcx == e.rcx && r11 == e.r11, {e.tag, " rcx/r11"}, rcx ^ r11, e.rcx ^ e.r11);
                chk(cs_sel == e.cs && ss_sel == e.ss, {e.tag, " selectors"}, {32'd0, cs_sel, ss_sel}, {32'd0, e.cs, e.ss});
                chk(cpl == e.cpl && gs_base == e.gs, {e.tag, " cpl/gs"}, gs_base ^ {62'd0, cpl}, e.gs ^ {62'd0, e.cpl});
            end
        end
    end

    task automatic msr_write(input logic [31:0] a, input logic [63:0] d);
        @(negedge clk);
        msr_wr = 1; msr_addr = a; msr_wdata = d;
        if (a == 32'hC000_0080) m_sce = d[0];
        if (a == 32'hC000_0081) m_sel = d;
        if (a == 32'hC000_0082) m_tgt = d;
        if (a == 32'hC000_0084) m_msk = d;
        if (a == 32'hC000_0102) m_kgs = d;
        @(negedge clk);
        msr_wr = 0;
    endtask

    task automatic msr_read(input logic [31:0] a, input logic [63:0] expv, input bit expf, input string req);
        @(negedge clk);
        msr_rd = 1; msr_addr = a;
        #1;
        chk(msr_rdata == expv, {req, " read data"}, msr_rdata, expv);
        chk(msr_fault == expf, {req, " msr fault"}, {63'd0, msr_fault}, {63'd0, expf});
        msr_rd = 0;
    endtask

    task automatic wb(input logic [1:0] sel, input logic [63:0] d);
        @(negedge clk);
        wb_en = 1; wb_sel = sel; wb_data = d;
        case (sel)
            2'd0: m_rcx = d;
            2'd1: m_r11 = d;
            2'd2: m_fl = d;
            default: m_gs = d;
        endcase
        @(negedge clk);
        wb_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(cpl == 2'd3 && pc == 0 && rflags == 64'h2, "R1 reset arch", rflags, 64'h2);
        chk(!done && !fault_ud && !fault_gp && gs_base == 0 && cs_sel == 0, "R1 reset flags", {63'd0, done}, 64'd0);
        msr_read(32'hC000_0082, 64'd0, 0, "R1 target reset");

        // R2 register file access
        msr_write(32'hC000_0081, 64'h0023_0010_0000_0000);
        msr_write(32'hC000_0082, 64'hFFFF_FFFF_8100_0000);
        msr_write(32'hC000_0084, 64'h0000_0000_0004_0700);
        msr_write(32'hC000_0102, 64'h0000_7000_CAFE_0000);
        msr_write(32'hC000_0080, 64'hFFFF_FFFF_FFFF_FFFE);
        msr_read(32'hC000_0080, 64'd0, 0, "R2 enable bit0 only");
        msr_read(32'hC000_0081, 64'h0023_0010_0000_0000, 0, "R2 selector pair");
        msr_read(32'hC000_0084, 64'h0000_0000_0004_0700, 0, "R2 clear mask");
        msr_write(32'hC000_0083, 64'hDEAD);
        msr_read(32'hC000_0083, 64'd0, 1, "R2 bad address");
        msr_read(32'hC000_0082, 64'hFFFF_FFFF_8100_0000, 0, "R2 bad write no effect");

        // R5 / R7 refused while disabled
        do_op(1, 0, 0, 64'h0000_0000_0040_1000, "R5 call disabled");
        do_op(0, 1, 0, 64'd0, "R7 return disabled");
        msr_write(32'hC000_0080, 64'h1);
        msr_read(32'hC000_0080, 64'd1, 0, "R2 enable set");

        // R12 write-back, R7 privilege faults
        wb(2'd2, 64'h0000_0000_0001_0ED7);
        wb(2'd3, 64'h0000_1111_2222_0000);
        do_op(0, 1, 0, 64'd0, "R7 return at level 3");
        do_op(0, 0, 1, 64'd0, "R7 swap at level 3");

        // R3 / R4 call
        do_op(1, 0, 0, 64'h0000_0000_0040_1000, "R3 R4 call");

        // R9 swap twice
        do_op(0, 0, 1, 64'd0, "R9 swap");
        msr_read(32'hC000_0102, 64'h0000_1111_2222_0000, 0, "R9 shadow after swap");
        do_op(0, 0, 1, 64'd0, "R9 swap back");
        msr_read(32'hC000_0102, 64'h0000_7000_CAFE_0000, 0, "R9 shadow restored");

        // R8 non-canonical return
        wb(2'd0, 64'h0000_8000_0000_0000);
        do_op(0, 1, 0, 64'd0, "R8 noncanonical return");

        // R6 good return with upper-half canonical address
        wb(2'd0, 64'hFFFF_8000_0000_1000);
        wb(2'd1, 64'h0000_0000_0000_0246);
        do_op(0, 1, 0, 64'd0, "R6 return");

        // R10 priority: call beats swap and return
        do_op(1, 0, 1, 64'h0000_0000_0050_2000, "R10 call over swap");
        do_op(0, 1, 1, 64'd0, "R10 return over swap");
        wb(2'd0, 64'h0000_0000_0060_0000);
        do_op(1, 1, 0, 64'h0000_0000_0070_3000, "R10 call over return");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all items consumed", 64'(exp_q.size()), 64'd0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule